// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

The block holds a 16-bit up-counting timer and one compare channel. Every clock the unit checks whether the timer count equals a compare value that is loaded through a simple write strobe. A 4-bit mode field, also written through a strobe, sets what a match does. A match can drive an output latch high or low. It can raise only the interrupt flag and leave the latch alone. In period-trigger mode it clears the timer, which makes the compare value a programmable timer period, and it sends a single-cycle conversion-start pulse to an external converter.

The unit acts on a match on the clock edge after the cycle in which the registered count equals the compare value. All outputs update together on that edge: the latch, the sticky match flag and the conversion pulse. A match is acted on once for each count value. A stalled timer therefore does not raise the flag or the pulse a second time. Software clears the two sticky flags with write-one-to-clear inputs.

Top module: `cmp_trig_unit`

## Requirements
- R1: After synchronous reset the timer count is 0, `pin_out` is low, both flags are clear, `conv_start` is low and the mode is off.
- R2: On each clock with `tmr_en` high the count grows by one, and it holds while `tmr_en` is low. Going from 0xFFFF to 0x0000 by counting sets `ovf_flag`.
- R3: In mode 4'b1000, when the count equals the compare value, the next edge sets `pin_out` high and sets `match_flag` on the same edge.
- R4: In mode 4'b1001 a match drives `pin_out` low on the next edge and sets `match_flag`.
- R5: In mode 4'b1010 a match sets `match_flag` only and leaves `pin_out` unchanged.
- R6: In mode 4'b1011 a match sets `match_flag` and loads the timer with 0 on the next edge, even when `tmr_en` is low. `pin_out` is unchanged.
- R7: In mode 4'b1011 a match pulses `conv_start` high for exactly one cycle, but only if `conv_en` is high in the matching cycle.
- R8: A timer clear caused by a mode 4'b1011 match never sets `ovf_flag`, even when the compare value is 0xFFFF.
- R9: Writing mode 4'b0000 forces `pin_out` low on the write edge.
- R10: Mode 4'b0000 and every code other than 4'b1000 to 4'b1011 are off: a match changes neither the flags, nor `pin_out`, nor the timer, nor `conv_start`.
- R11: A match is acted on once per count value. While the timer stays on the matching value, a cleared `match_flag` stays clear and no further pulse appears.
- R12: `match_flag` and `ovf_flag` stay set until their clear input is high on an edge. If a set and a clear arrive on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_en | input | 1 | Timer count enable |
| cmp_wr | input | 1 | Load strobe for the compare value |
| cmp_data | input | 16 | New compare value |
| mode_wr | input | 1 | Load strobe for the mode field |
| mode_data | input | 4 | New mode code |
| conv_en | input | 1 | Converter enable; gates `conv_start` |
| match_clr | input | 1 | Write-one-to-clear for `match_flag` |
| ovf_clr | input | 1 | Write-one-to-clear for `ovf_flag` |
| timer_count | output | 16 | Current timer count |
| pin_out | output | 1 | Compare output latch |
| match_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
A corrupted once-per-value marker shows up within one cycle of a stalled match. Either a cleared `match_flag` comes straight back, or an expected action is missing on the edge after the count reaches the compare value. A wrong mode decode shows on that same edge as a wrong `pin_out` level, a timer that was or was not reloaded with zero, or a `conv_start` pulse that is missing or extra. A wrong choice between wrap and period clear can only show at the 0xFFFF boundary, so the bench runs the timer through a full natural wrap and through a period clear at 0xFFFF, and checks `ovf_flag` right after each.

// File: rtl/cmp_trig_pkg.sv
package cmp_trig_pkg;

    // Mode codes; all codes not listed behave as off.
    typedef enum logic [3:0] {
        MODE_OFF         = 4'b0000,
        MODE_DRIVE_HI    = 4'b1000,
        MODE_DRIVE_LO    = 4'b1001,
        MODE_FLAG_ONLY   = 4'b1010,
        MODE_PERIOD_TRIG = 4'b1011
    } mode_e;

    typedef struct packed {
        logic active;
        logic drive_hi;
        logic drive_lo;
        logic period_trig;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] code);
        mode_dec_t d;
        d.active      = (code[3:2] == 2'b10);
        d.drive_hi    = (code == MODE_DRIVE_HI);
        d.drive_lo    = (code == MODE_DRIVE_LO);
        d.period_trig = (code == MODE_PERIOD_TRIG);
        return d;
    endfunction

endpackage

// File: rtl/cmp_trig_timer.sv
module cmp_trig_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             period_clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             moving
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        if (period_clr)
            count_nxt = '0;
        else if (cnt_en)
            count_nxt = count + 1'b1;
        else
            count_nxt = count;
    end

    // natural wrap only; a period clear takes priority and never counts
    assign wrap   = cnt_en && !period_clr && (count == TOP);
    assign moving = (count_nxt != count);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count_nxt;
    end

endmodule

// File: rtl/cmp_trig_match.sv
module cmp_trig_match
    import cmp_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  mode_dec_t        dec,
    input  logic             moving,
    input  logic             cfg_write,
    output logic             fire
);
    // set once the current count value has been acted on
    logic done;
    logic equal;

    assign equal = (count == cmp_val);
    assign fire  = dec.active && equal && !done;

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (moving || cfg_write)
            done <= 1'b0;
        else if (fire)
            done <= 1'b1;
    end

endmodule

// File: rtl/cmp_trig_action.sv
module cmp_trig_action
    import cmp_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  mode_dec_t dec,
    input  logic      conv_en,
    input  logic      zero_write,
    input  logic      wrap,
    input  logic      match_clr,
    input  logic      ovf_clr,
    output logic      pin_out,
    output logic      match_flag,
    output logic      ovf_flag,
    output logic      conv_start
);

    always_ff @(posedge clk) begin
        if (rst || zero_write)
            pin_out <= 1'b0;
        else if (fire && dec.drive_hi)
            pin_out <= 1'b1;
        else if (fire && dec.drive_lo)
            pin_out <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            match_flag <= 1'b0;
        else if (fire)
            match_flag <= 1'b1;
        else if (match_clr)
            match_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_flag <= 1'b0;
        else if (wrap)
            ovf_flag <= 1'b1;
        else if (ovf_clr)
            ovf_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            conv_start <= 1'b0;
        else
            conv_start <= fire && dec.period_trig && conv_en;
    end

endmodule

// File: rtl/cmp_trig_unit.sv
module cmp_trig_unit
    import cmp_trig_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_en,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_data,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              conv_en,
    input  logic              match_clr,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  timer_count,
    output logic              pin_out,
    output logic              match_flag,
    output logic              ovf_flag,
    output logic              conv_start
);
    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    mode_dec_t         dec;
    logic              fire;
    logic              period_clr;
    logic              wrap;
    logic              moving;
    logic              zero_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            mode_q <= '0;
        end else begin
            if (cmp_wr)
                cmp_q <= cmp_data;
            if (mode_wr)
                mode_q <= mode_data;
        end
    end

    assign dec        = decode_mode(4'(mode_q));
    assign period_clr = fire && dec.period_trig;
    assign zero_write = mode_wr && (mode_data == '0);

    cmp_trig_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (tmr_en),
        .period_clr (period_clr),
        .count      (timer_count),
        .wrap       (wrap),
        .moving     (moving)
    );

    cmp_trig_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .count     (timer_count),
        .cmp_val   (cmp_q),
        .dec       (dec),
        .moving    (moving),
        .cfg_write (cmp_wr || mode_wr),
        .fire      (fire)
    );

    cmp_trig_action u_action (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .dec        (dec),
        .conv_en    (conv_en),
        .zero_write (zero_write),
        .wrap       (wrap),
        .match_clr  (match_clr),
        .ovf_clr    (ovf_clr),
        .pin_out    (pin_out),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag),
        .conv_start (conv_start)
    );

endmodule

// File: rtl/cmp_trig_unit_chk.sv
module cmp_trig_unit_chk #(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tmr_en,
    input logic [CNT_W-1:0]  timer_count,
    input logic              pin_out,
    input logic              match_flag,
    input logic              ovf_flag,
    input logic              conv_start,
    input logic              match_clr,
    input logic              mode_wr,
    input logic [MODE_W-1:0] mode_data,
    input logic [MODE_W-1:0] mode_q,
    input logic              fire,
    input logic              period_clr
);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && !period_clr) |=> timer_count == CNT_W'($past(timer_count) + 1'b1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !period_clr) |=> $stable(timer_count));

    // R6
    period_clear_chk: assert property (@(posedge clk) disable iff (rst)
        period_clr |=> timer_count == '0);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (period_clr && !ovf_flag) |=> !ovf_flag);

    // R7
    conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !match_clr) |=> match_flag);

    // R9
    zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_data == '0) |=> !pin_out);

    // R5
    flag_only_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_q == 4'b1010 && !mode_wr) |=> ($stable(pin_out) && match_flag));

endmodule

bind cmp_trig_unit cmp_trig_unit_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tmr_en      (tmr_en),
    .timer_count (timer_count),
    .pin_out     (pin_out),
    .match_flag  (match_flag),
    .ovf_flag    (ovf_flag),
    .conv_start  (conv_start),
    .match_clr   (match_clr),
    .mode_wr     (mode_wr),
    .mode_data   (mode_data),
    .mode_q      (mode_q),
    .fire        (fire),
    .period_clr  (period_clr)
);

// File: tb/cmp_trig_unit_test.sv
module cmp_trig_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_en = 1'b0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_data = '0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_data = '0;
    logic        conv_en = 1'b0;
    logic        match_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] timer_count;
    logic        pin_out;
    logic        match_flag;
    logic        ovf_flag;
    logic        conv_start;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    cmp_trig_unit uut (
        .clk         (clk),
        .rst         (rst),
        .tmr_en      (tmr_en),
        .cmp_wr      (cmp_wr),
        .cmp_data    (cmp_data),
        .mode_wr     (mode_wr),
        .mode_data   (mode_data),
        .conv_en     (conv_en),
        .match_clr   (match_clr),
        .ovf_clr     (ovf_clr),
        .timer_count (timer_count),
        .pin_out     (pin_out),
        .match_flag  (match_flag),
        .ovf_flag    (ovf_flag),
        .conv_start  (conv_start)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] cmp;
        logic        ce;
        logic        pin;
        logic        flg;
        logic        cv;
        logic [15:0] cnt;
    } vec_t;

    // mode, compare, conv_en -> pin, flag, pulse, count after the action edge
    localparam vec_t VECS [8] = '{
        '{4'b1000, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0, 16'd5},  // R3
        '{4'b1010, 16'd7, 1'b1, 1'b0, 1'b1, 1'b0, 16'd7},  // R5
        '{4'b1011, 16'd9, 1'b1, 1'b0, 1'b1, 1'b1, 16'd0},  // R6 R7
        '{4'b1011, 16'd4, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0},  // R7 gated
        '{4'b0000, 16'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'd6},  // R10
        '{4'b0101, 16'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'd3},  // R10
        '{4'b1100, 16'd8, 1'b1, 1'b0, 1'b0, 1'b0, 16'd8},  // R10
        '{4'b1000, 16'd1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1}   // R3
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tmr_en = 1'b0;
        cmp_wr = 1'b0;
        mode_wr = 1'b0;
        conv_en = 1'b0;
        match_clr = 1'b0;
        ovf_clr = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic write_cmp(input logic [15:0] d);
        cmp_wr = 1'b1;
        cmp_data = d;
        tick();
        cmp_wr = 1'b0;
    endtask

    task automatic write_mode(input logic [3:0] d);
        mode_wr = 1'b1;
        mode_data = d;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1
        check("R1 count", 32'(timer_count), 0);
        check("R1 pin", 32'(pin_out), 0);
        check("R1 match_flag", 32'(match_flag), 0);
        check("R1 ovf_flag", 32'(ovf_flag), 0);
        check("R1 conv_start", 32'(conv_start), 0);

        // table walk: R3 R5 R6 R7 R10 R11 R12
        for (int i = 0; i < 8; i++) begin
            do_reset();
            write_cmp(VECS[i].cmp);
            write_mode(VECS[i].mode);
            conv_en = VECS[i].ce;
            tmr_en = 1'b1;
            repeat (int'(VECS[i].cmp)) tick();
            tmr_en = 1'b0;
            tick();
            check("R3/R5/R10 pin", 32'(pin_out), 32'(VECS[i].pin));
            check("R3/R6/R10 flag", 32'(match_flag), 32'(VECS[i].flg));
            check("R7 conv_start", 32'(conv_start), 32'(VECS[i].cv));
            check("R6 count", 32'(timer_count), 32'(VECS[i].cnt));
            tick();
            check("R7 pulse width", 32'(conv_start), 0);
            check("R12 flag sticky", 32'(match_flag), 32'(VECS[i].flg));
        end

        // R4: set high, then a later match drives low
        do_reset();
        write_cmp(16'd3);
        write_mode(4'b1000);
        tmr_en = 1'b1;
        repeat (3) tick();
        tmr_en = 1'b0;
        tick();
        check("R3 pin high", 32'(pin_out), 1);
        write_cmp(16'd6);
        write_mode(4'b1001);
        tmr_en = 1'b1;
        repeat (3) tick();
        tmr_en = 1'b0;
        check("R4 pin before match", 32'(pin_out), 1);
        tick();
        check("R4 pin low", 32'(pin_out), 0);

        // R9: match re-armed by mode write, then zero write clears latch
        write_mode(4'b1000);
        tick();
        check("R9 pin high before", 32'(pin_out), 1);
        write_mode(4'b0000);
        check("R9 pin cleared", 32'(pin_out), 0);

        // R2: natural wrap, R12 overflow clear
        do_reset();
        tmr_en = 1'b1;
        repeat (65535) tick();
        check("R2 count top", 32'(timer_count), 32'h0000ffff);
        check("R2 ovf before wrap", 32'(ovf_flag), 0);
        tick();
        check("R2 count wrapped", 32'(timer_count), 0);
        check("R2 ovf set", 32'(ovf_flag), 1);
        tmr_en = 1'b0;
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        check("R12 ovf cleared", 32'(ovf_flag), 0);

        // R8: period clear at 0xFFFF sets no overflow
        write_cmp(16'hffff);
        write_mode(4'b1011);
        conv_en = 1'b1;
        tmr_en = 1'b1;
        repeat (65535) tick();
        check("R8 count top", 32'(timer_count), 32'h0000ffff);
        tick();
        tmr_en = 1'b0;
        check("R8 count cleared", 32'(timer_count), 0);
        check("R8 ovf", 32'(ovf_flag), 0);
        check("R8 flag", 32'(match_flag), 1);
        check("R7 pulse", 32'(conv_start), 1);

        // R11: stalled match acts once
        do_reset();
        write_cmp(16'd2);
        write_mode(4'b1010);
        tmr_en = 1'b1;
        repeat (2) tick();
        tmr_en = 1'b0;
        tick();
        check("R11 flag set", 32'(match_flag), 1);
        match_clr = 1'b1;
        tick();
        match_clr = 1'b0;
        check("R12 flag cleared", 32'(match_flag), 0);
        repeat (3) tick();
        check("R11 no repeat", 32'(match_flag), 0);
        check("R2 count held", 32'(timer_count), 2);

        // R12: set wins over clear on the same edge
        do_reset();
        write_cmp(16'd2);
        write_mode(4'b1010);
        tmr_en = 1'b1;
        repeat (2) tick();
        tmr_en = 1'b0;
        match_clr = 1'b1;
        tick();
        match_clr = 1'b0;
        check("R12 set priority", 32'(match_flag), 1);

        finish_run();
    end

endmodule